// File: doc/BRIEF.md
# Compact-ISA Arithmetic and Logic Unit with Condition Flags

This block is the register-to-register arithmetic and logic unit for a processor that executes a 16-bit compressed instruction set on 32-bit data. Each evaluation takes a 4-bit operation code, the destination register's current value, the source register's value and the incoming condition flags (negative N, zero Z, carry C, overflow V). From these it produces the result, a write-enable for the destination register, the updated flags, and, for multiply, the number of extra cycles the multiply takes.

The block is purely combinational. Logical operations, add and subtract with carry, compares, bit test, negate, move-not, bit-clear and multiply are computed here. The four operation codes that shift by a register amount are not computed here. The block flags them for a separate shifter, and it leaves the register and the flags untouched for those codes. All arithmetic shares one adder. Compare and test operations update the flags but suppress the register write.

Top module: `cmpct_alu`

## Requirements
- R1: Op codes 0 (AND), 1 (EOR), 12 (ORR), 14 (BIC: dst AND NOT src) and 15 (MVN: NOT src) return the bitwise result with write-enable high.
- R2: Op codes 0, 1, 8, 12, 13, 14 and 15 pass incoming C (flags bit 1) and V (flags bit 0) through unchanged.
- R3: Op code 5 (ADC) returns dst + src + C. C out is bit 32 of the exact unsigned sum including the carry-in. V out is set when the exact signed sum falls outside the 32-bit signed range.
- R4: Op code 6 (SBC) returns dst - src - (1 - C). C out is 1 when no borrow occurs, meaning dst >= src + (1 - C) as unsigned values. V out is set on signed-range overflow. Write-enable is high.
- R5: Op code 10 (CMP) sets all four flags as for dst - src with no borrow-in. Op code 11 (CMN) sets them as for dst + src with no carry-in. Both hold write-enable low.
- R6: Op code 8 (TST) sets N and Z from dst AND src and holds write-enable low.
- R7: Op code 9 (NEG) returns 0 - src with write-enable high and subtract flags: C is set only when src is 0, and V is set only when src is 0x80000000.
- R8: Op code 13 (MUL) returns the low 32 bits of dst * src with write-enable high.
- R9: For MUL the cycle-count output is 1 if src bits 31:8 are all equal, otherwise 2 if bits 31:16 are, otherwise 3 if bits 31:24 are, otherwise 4. For every other op it is 0.
- R10: Op codes 2, 3, 4 and 7 raise the shift-select output, hold write-enable low and return the flags unchanged. Shift-select is low for all other codes.
- R11: Every op that updates flags sets N to result bit 31 and sets Z exactly when the result is zero. The flags vector is {N,Z,C,V} from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| dst_i | input | 32 | Destination register value (first operand) |
| src_i | input | 32 | Source register value (second operand) |
| flags_i | input | 4 | Incoming flags {N,Z,C,V} |
| res_o | output | 32 | Result value |
| wr_en_o | output | 1 | Destination register write-enable |
| flags_o | output | 4 | Updated flags {N,Z,C,V} |
| mul_cyc_o | output | 3 | Multiply cycle count, 0 for non-multiply ops |
| shift_sel_o | output | 1 | Operation belongs to the external shifter |

## Verification
The carry-in term and the carry/overflow outputs can decide the result in the same evaluation. For example, ADC of 0x7FFFFFFF + 0 with C=1 overflows only because of the carry-in, and SBC of 0 - 0 with C=0 must report a borrow. These vectors are applied on purpose, and the bench judges them against exact 64-bit signed and unsigned arithmetic. Multiply likewise produces a wrapped product, its Z flag and its cycle count together, so values at the edges of the byte groups (0x80, 0x100, 0xFFFF8000, 0xFF800000) are run through MUL and all three outputs are compared at once. Random vectors mix boundary operands with every op code and every flag pattern.

// File: rtl/cmpct_alu_pkg.sv
package cmpct_alu_pkg;

   typedef enum logic [3:0] {
      ALU_AND = 4'h0,
      ALU_EOR = 4'h1,
      ALU_LSL = 4'h2,
      ALU_LSR = 4'h3,
      ALU_ASR = 4'h4,
      ALU_ADC = 4'h5,
      ALU_SBC = 4'h6,
      ALU_ROR = 4'h7,
      ALU_TST = 4'h8,
      ALU_NEG = 4'h9,
      ALU_CMP = 4'hA,
      ALU_CMN = 4'hB,
      ALU_ORR = 4'hC,
      ALU_MUL = 4'hD,
      ALU_BIC = 4'hE,
      ALU_MVN = 4'hF
   } alu_op_e;

   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_C = 1;
   localparam int FLG_V = 0;

endpackage

// File: rtl/cmpct_alu_logic.sv
module cmpct_alu_logic
   import cmpct_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   y
);

   always_comb begin
      unique case (op)
         ALU_EOR: y = a ^ b;
         ALU_ORR: y = a | b;
         ALU_BIC: y = a & ~b;
         ALU_MVN: y = ~b;
         default: y = a & b;   // AND and TST
      endcase
   end

endmodule

// File: rtl/cmpct_alu_addsub.sv
module cmpct_alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);

   logic [W-1:0] b_eff;

   assign b_eff = sub ? ~b : b;
   assign {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
   assign ovf = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

   always_comb begin
      if (!$isunknown({a, b, sub, cin})) begin
         // R4
         sub_zero_borrow_chk: assert (!(sub && cin && (a == b)) || (cout && (sum == '0)))
            else $error("subtract of equal operands must give zero with no borrow");
      end
   end

endmodule

// File: rtl/cmpct_alu_mul.sv
module cmpct_alu_mul #(
   parameter int W   = 32,
   parameter int CYW = 3
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   prod,
   output logic [CYW-1:0] cycles
);

   localparam int NB = W / 8;

   logic [NB-1:1] group_flat;

   assign prod = a * b;

   for (genvar k = 1; k < NB; k++) begin : g_grp
      assign group_flat[k] = (&b[W-1:8*k]) | ~(|b[W-1:8*k]);
   end

   always_comb begin
      cycles = CYW'(NB);
      for (int k = NB - 1; k >= 1; k--) begin
         if (group_flat[k]) cycles = CYW'(k);
      end
   end

   always_comb begin
      if (!$isunknown(b)) begin
         // R9
         mul_one_cycle_chk: assert ((cycles != CYW'(1)) || ((b >> 8) == '0) || ((~b >> 8) == '0))
            else $error("single-cycle count with wide source");
         // R9
         mul_cycle_range_chk: assert ((cycles >= CYW'(1)) && (cycles <= CYW'(NB)))
            else $error("cycle count out of range");
      end
   end

endmodule

// File: rtl/cmpct_alu.sv
module cmpct_alu
   import cmpct_alu_pkg::*;
#(
   parameter int W   = 32,
   parameter int CYW = $clog2(W / 8 + 1)
) (
   input  logic [3:0]     op_i,
   input  logic [W-1:0]   dst_i,
   input  logic [W-1:0]   src_i,
   input  logic [3:0]     flags_i,
   output logic [W-1:0]   res_o,
   output logic           wr_en_o,
   output logic [3:0]     flags_o,
   output logic [CYW-1:0] mul_cyc_o,
   output logic           shift_sel_o
);

   localparam int NB = W / 8;

   if ((W % 8) != 0 || W < 16) begin : g_bad_width
      $error("cmpct_alu: W must be a multiple of 8 and at least 16");
   end
   if (CYW < $clog2(NB + 1)) begin : g_bad_cyw
      $error("cmpct_alu: CYW too narrow for the cycle count");
   end

   alu_op_e        op;
   logic [W-1:0]   log_y;
   logic [W-1:0]   as_a, as_sum, mul_p;
   logic           as_sub, as_cin, as_cout, as_ovf;
   logic [CYW-1:0] mul_cyc;
   logic           upd_nz, upd_cv;

   assign op = alu_op_e'(op_i);

   cmpct_alu_logic #(.W(W)) u_logic (
      .op (op), .a (dst_i), .b (src_i), .y (log_y)
   );

   always_comb begin
      as_a   = dst_i;
      as_sub = 1'b0;
      as_cin = 1'b0;
      unique case (op)
         ALU_ADC: as_cin = flags_i[FLG_C];
         ALU_SBC: begin as_sub = 1'b1; as_cin = flags_i[FLG_C]; end
         ALU_CMP: begin as_sub = 1'b1; as_cin = 1'b1; end
         ALU_NEG: begin as_sub = 1'b1; as_cin = 1'b1; as_a = '0; end
         default: ;
      endcase
   end

   cmpct_alu_addsub #(.W(W)) u_addsub (
      .a (as_a), .b (src_i), .sub (as_sub), .cin (as_cin),
      .sum (as_sum), .cout (as_cout), .ovf (as_ovf)
   );

   cmpct_alu_mul #(.W(W), .CYW(CYW)) u_mul (
      .a (dst_i), .b (src_i), .prod (mul_p), .cycles (mul_cyc)
   );

   always_comb begin
      res_o       = dst_i;
      wr_en_o     = 1'b0;
      upd_nz      = 1'b0;
      upd_cv      = 1'b0;
      mul_cyc_o   = '0;
      shift_sel_o = 1'b0;
      unique case (op)
         ALU_AND, ALU_EOR, ALU_ORR, ALU_BIC, ALU_MVN: begin
            res_o = log_y; wr_en_o = 1'b1; upd_nz = 1'b1;
         end
         ALU_TST: begin
            res_o = log_y; upd_nz = 1'b1;
         end
         ALU_ADC, ALU_SBC, ALU_NEG: begin
            res_o = as_sum; wr_en_o = 1'b1; upd_nz = 1'b1; upd_cv = 1'b1;
         end
         ALU_CMP, ALU_CMN: begin
            res_o = as_sum; upd_nz = 1'b1; upd_cv = 1'b1;
         end
         ALU_MUL: begin
            res_o = mul_p; wr_en_o = 1'b1; upd_nz = 1'b1; mul_cyc_o = mul_cyc;
         end
         ALU_LSL, ALU_LSR, ALU_ASR, ALU_ROR: shift_sel_o = 1'b1;
         default: ;
      endcase
   end

   assign flags_o[FLG_N] = upd_nz ? res_o[W-1]     : flags_i[FLG_N];
   assign flags_o[FLG_Z] = upd_nz ? (res_o == '0)  : flags_i[FLG_Z];
   assign flags_o[FLG_C] = upd_cv ? as_cout        : flags_i[FLG_C];
   assign flags_o[FLG_V] = upd_cv ? as_ovf         : flags_i[FLG_V];

   always_comb begin
      if (!$isunknown({op_i, dst_i, src_i, flags_i})) begin
         // R2
         logic_cv_keep_chk: assert (!(op inside {ALU_AND, ALU_EOR, ALU_TST, ALU_ORR, ALU_MUL, ALU_BIC, ALU_MVN})
                                    || (flags_o[1:0] == flags_i[1:0]))
            else $error("C/V altered by a logical op");
         // R5
         cmp_no_write_chk: assert (!(op inside {ALU_TST, ALU_CMP, ALU_CMN}) || !wr_en_o)
            else $error("compare or test wrote the destination");
         // R7
         neg_sum_chk: assert ((op != ALU_NEG) || ((res_o + src_i) == '0))
            else $error("negate result plus source is not zero");
         // R10
         shift_pass_chk: assert (!shift_sel_o || (!wr_en_o && (flags_o == flags_i) && (mul_cyc_o == '0)))
            else $error("shift op touched register or flags");
         // R11
         nz_track_chk: assert (!wr_en_o || ((flags_o[3] == res_o[W-1]) && (flags_o[2] == (res_o == '0))))
            else $error("N/Z disagree with written result");
      end
   end

endmodule

// File: tb/cmpct_alu_tb.sv
module cmpct_alu_tb;

   localparam int W   = 32;
   localparam int CYW = 3;
   localparam longint SMAX = 64'sd2147483647;
   localparam longint SMIN = -64'sd2147483648;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [3:0]     op_i = '0;
   logic [W-1:0]   dst_i = '0, src_i = '0;
   logic [3:0]     flags_i = '0;
   logic [W-1:0]   res_o;
   logic           wr_en_o;
   logic [3:0]     flags_o;
   logic [CYW-1:0] mul_cyc_o;
   logic           shift_sel_o;

   int compared = 0;
   int mismatched = 0;

   always #2 clk = ~clk;

   cmpct_alu #(.W(W), .CYW(CYW)) u_dut (
      .op_i (op_i), .dst_i (dst_i), .src_i (src_i), .flags_i (flags_i),
      .res_o (res_o), .wr_en_o (wr_en_o), .flags_o (flags_o),
      .mul_cyc_o (mul_cyc_o), .shift_sel_o (shift_sel_o)
   );

   function automatic string op_tag(input logic [3:0] op);
      case (op)
         4'h5: return "R3";
         4'h6: return "R4";
         4'h8: return "R6";
         4'h9: return "R7";
         4'hA, 4'hB: return "R5";
         4'hD: return "R8";
         4'h2, 4'h3, 4'h4, 4'h7: return "R10";
         default: return "R1";
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual=%0h expected=%0h (op=%0h dst=%08h src=%08h flags=%0h)",
                  tag, what, act, exp, op_i, dst_i, src_i, flags_i);
      end
   endtask

   // Behavioural reference: exact 64-bit arithmetic, no shared structure with the design.
   task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] f, output logic [31:0] r, output logic we,
                        output logic [3:0] fo, output logic [2:0] cy, output logic sh);
      longint ua, ub, sa, sb, ci, full, sfull;
      logic nz, cv, nc, nv;
      ua = {32'h0, a}; ub = {32'h0, b};
      sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b};
      ci = f[1] ? 64'd1 : 64'd0;
      r = a; we = 1'b0; fo = f; cy = 3'd0; sh = 1'b0;
      nz = 1'b0; cv = 1'b0; nc = f[1]; nv = f[0];
      full = 0; sfull = 0;
      case (op)
         4'h0: begin r = a & b;  we = 1'b1; nz = 1'b1; end
         4'h1: begin r = a ^ b;  we = 1'b1; nz = 1'b1; end
         4'hC: begin r = a | b;  we = 1'b1; nz = 1'b1; end
         4'hE: begin r = a & ~b; we = 1'b1; nz = 1'b1; end
         4'hF: begin r = ~b;     we = 1'b1; nz = 1'b1; end
         4'h8: begin r = a & b;  nz = 1'b1; end
         4'h5, 4'hB: begin
            if (op == 4'hB) ci = 0;
            full = ua + ub + ci; sfull = sa + sb + ci;
            r = full[31:0]; nc = full[32];
            nv = (sfull > SMAX) || (sfull < SMIN);
            we = (op == 4'h5); nz = 1'b1; cv = 1'b1;
         end
         4'h6, 4'hA, 4'h9: begin
            if (op != 4'h6) ci = 1;
            if (op == 4'h9) begin ua = 0; sa = 0; end
            full = ua - ub - (64'd1 - ci); sfull = sa - sb - (64'd1 - ci);
            r = full[31:0]; nc = (ua >= ub + (64'd1 - ci));
            nv = (sfull > SMAX) || (sfull < SMIN);
            we = (op != 4'hA); nz = 1'b1; cv = 1'b1;
         end
         4'hD: begin
            full = ua * ub; r = full[31:0]; we = 1'b1; nz = 1'b1;
            if (b <= 32'h0000_00FF || b >= 32'hFFFF_FF00) cy = 3'd1;
            else if (b <= 32'h0000_FFFF || b >= 32'hFFFF_0000) cy = 3'd2;
            else if (b <= 32'h00FF_FFFF || b >= 32'hFF00_0000) cy = 3'd3;
            else cy = 3'd4;
         end
         default: sh = 1'b1;
      endcase
      if (nz) begin fo[3] = r[31]; fo[2] = (r == 32'h0); end
      if (cv) begin fo[1] = nc; fo[0] = nv; end
   endtask

   task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] f);
      logic [31:0] er; logic ewe, esh; logic [3:0] ef; logic [2:0] ecy;
      string t, cvt;
      @(posedge clk);
      #1;
      op_i = op; dst_i = a; src_i = b; flags_i = f;
      @(negedge clk);
      model(op, a, b, f, er, ewe, ef, ecy, esh);
      t = op_tag(op);
      cvt = (op inside {4'h0, 4'h1, 4'h8, 4'hC, 4'hD, 4'hE, 4'hF}) ? "R2" : t;
      if (ewe || op inside {4'h8, 4'hA, 4'hB}) chk(t, "result", longint'(res_o), longint'(er));
      chk(t, "wr_en", longint'(wr_en_o), longint'(ewe));
      chk("R11", "N/Z", longint'(flags_o[3:2]), longint'(ef[3:2]));
      chk(cvt, "C/V", longint'(flags_o[1:0]), longint'(ef[1:0]));
      chk("R9", "mul_cycles", longint'(mul_cyc_o), longint'(ecy));
      chk("R10", "shift_sel", longint'(shift_sel_o), longint'(esh));
   endtask

   function automatic logic [31:0] pick();
      logic [31:0] sp [12] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                               32'h80, 32'h100, 32'hFFFF_FF00, 32'hFFFF_8000, 32'hFF80_0000,
                               32'h0100_0000, 32'h0001_0000};
      if ($urandom_range(0, 2) == 0) return sp[$urandom_range(0, 11)];
      return $urandom;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 idle state: AND of zero operands, zero flags in
      chk("R1", "idle result", longint'(res_o), 0);
      chk("R1", "idle flags", longint'(flags_o), 64'h4);
      rst_n = 1'b1;

      // R1 logical ops
      apply(4'h0, 32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0011);
      apply(4'h1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'b1010);
      apply(4'hC, 32'h8000_0000, 32'h0000_0001, 4'b0100);
      apply(4'hE, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'b0001);
      apply(4'hF, 32'h1234_5678, 32'hFFFF_FFFF, 4'b0010);
      // R3 carry-in alone causes overflow; carry-in wraps to zero
      apply(4'h5, 32'h7FFF_FFFF, 32'h0, 4'b0010);
      apply(4'h5, 32'hFFFF_FFFF, 32'h0, 4'b0010);
      apply(4'h5, 32'h8000_0000, 32'h8000_0000, 4'b0000);
      // R4 borrow-in from C=0
      apply(4'h6, 32'h0, 32'h0, 4'b0000);
      apply(4'h6, 32'h0, 32'h0, 4'b0010);
      apply(4'h6, 32'h8000_0000, 32'h1, 4'b0010);
      // R5 compares, write suppressed
      apply(4'hA, 32'h5, 32'h5, 4'b0000);
      apply(4'hA, 32'h3, 32'h5, 4'b0011);
      apply(4'hB, 32'hFFFF_FFFF, 32'h1, 4'b0010);
      // R6 test
      apply(4'h8, 32'hF000_0000, 32'h0F00_0000, 4'b0011);
      // R7 negate edges
      apply(4'h9, 32'h1234, 32'h0, 4'b0000);
      apply(4'h9, 32'h0, 32'h8000_0000, 4'b0000);
      // R8 R9 multiply with cycle-count boundaries
      apply(4'hD, 32'h3, 32'h80, 4'b0011);
      apply(4'hD, 32'h3, 32'h100, 4'b0000);
      apply(4'hD, 32'h1, 32'hFFFF_8000, 4'b0000);
      apply(4'hD, 32'h1, 32'hFF80_0000, 4'b0000);
      apply(4'hD, 32'h2, 32'h0100_0000, 4'b0000);
      apply(4'hD, 32'h0001_0000, 32'h0001_0000, 4'b0011);
      // R10 shift codes pass through
      apply(4'h2, 32'h1, 32'h4, 4'b1111);
      apply(4'h7, 32'h1, 32'h4, 4'b0000);

      // R11 and all the above under mixed random vectors
      for (int i = 0; i < 1500; i++) begin
         apply(4'($urandom_range(0, 15)), pick(), pick(), 4'($urandom_range(0, 15)));
      end

      @(posedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule